// File: doc/BRIEF.md
# Self-Clearing Interrupt Status Register

This block collects three interrupt sources of a real-time clock (periodic tick, alarm match, update-ended) into one status byte and one active-low interrupt request. Each source delivers a single-cycle event pulse. The event latches a sticky flag whether or not that source is enabled. Three enable inputs decide which flags may pull the interrupt line low.

The host reads the status with a two-phase handshake. A read-start pulse takes a snapshot of the byte, clears every flag, and opens a read window. A read-end pulse closes the window. The snapshot stays on the read data bus until the next read starts. Events that arrive while the window is open, including on the start and end cycles, go into a separate pending store. They are merged into the flags when the window closes, so the clear can never remove an event the host has not yet seen.

Top module: `irq_status_reg`

## Requirements
- R1: An event pulse sets its source flag regardless of that source's enable, and the flag stays set until a read clears it.
- R2: A read start loads rd_data with the status byte: bit 6 periodic, bit 5 alarm, bit 4 update-ended, bits 3 to 0 zero. Any mix of the three flags may be set in one snapshot.
- R3: A read start clears every flag and the summary. In the next cycle irq_n is high unless a pending event is merged later.
- R4: rd_data holds its value from one read start until the next read start.
- R5: An event arriving from the read-start cycle through the read-end cycle is not cleared by that read. It sets its flag after the read window closes and appears in the following read.
- R6: irq_n is low exactly while at least one source has both its flag and its enable set.
- R7: Bit 7 of the snapshot is the summary bit. It equals the inverse of irq_n in the cycle of the read start.
- R8: A read start while a window is already open, and a read end while no window is open, have no effect.
- R9: A synchronous active-high reset clears all flags and pending events, closes the read window, sets rd_data to zero, and drives irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_periodic | input | 1 | Periodic tick event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| en_periodic | input | 1 | Interrupt enable for the periodic source |
| en_alarm | input | 1 | Interrupt enable for the alarm source |
| en_update | input | 1 | Interrupt enable for the update-ended source |
| rd_start | input | 1 | Pulse that begins a status read |
| rd_end | input | 1 | Pulse that completes a status read |
| rd_data | output | 8 | Status snapshot taken at the last read start |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag that fails to latch or to clear shows up on irq_n in the cycle after the event or read start, provided that source is enabled. With the source disabled, the fault only appears in the snapshot of the next read. A pending event that is lost or merged too early appears either as a missing bit in the read after the window closes or as irq_n falling inside the window. A summary bit that disagrees with the interrupt line is visible in bit 7 of the snapshot one cycle after the read start.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC      = 3;
  localparam int DATA_W       = 8;
  localparam int SRC_PERIODIC = 0;
  localparam int SRC_ALARM    = 1;
  localparam int SRC_UPDATE   = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         start,
  input  logic         finish,
  input  logic         in_read,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_slice
    logic flag_d, pend_d;

    always_comb begin
      flag_d = flag_q[i];
      pend_d = pend_q[i];
      if (start) begin
        flag_d = 1'b0;
        pend_d = ev[i];
      end else if (finish) begin
        flag_d = flag_q[i] | pend_q[i] | ev[i];
        pend_d = 1'b0;
      end else if (in_read) begin
        pend_d = pend_q[i] | ev[i];
      end else begin
        flag_d = flag_q[i] | ev[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= flag_d;
        pend_q[i] <= pend_d;
      end
    end
  end
endmodule

// File: rtl/irq_read_capture.sv
module irq_read_capture #(
  parameter int N      = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              rd_end,
  input  logic [N-1:0]      flags,
  input  logic [N-1:0]      en,
  output logic              in_read,
  output logic              start,
  output logic              finish,
  output logic              irq_active,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SUM_BIT  = DATA_W - 1;
  localparam int FLAG_TOP = DATA_W - 2;

  logic [DATA_W-1:0] snap;

  assign start      = rd_start & ~in_read;
  assign finish     = rd_end & in_read;
  assign irq_active = |(flags & en);

  always_comb begin
    snap          = '0;
    snap[SUM_BIT] = irq_active;
    for (int i = 0; i < N; i++) begin
      snap[FLAG_TOP - i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_read <= 1'b0;
      rd_data <= '0;
    end else begin
      if (start) begin
        in_read <= 1'b1;
        rd_data <= snap;
      end else if (finish) begin
        in_read <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_periodic,
  input  logic          ev_alarm,
  input  logic          ev_update,
  input  logic          en_periodic,
  input  logic          en_alarm,
  input  logic          en_update,
  input  logic          rd_start,
  input  logic          rd_end,
  output logic [DW-1:0] rd_data,
  output logic          irq_n
);
  logic [NUM_SRC-1:0] ev_vec, en_vec, flag_q, pend_q;
  logic in_read, start, finish, irq_active;

  always_comb begin
    ev_vec               = '0;
    en_vec               = '0;
    ev_vec[SRC_PERIODIC] = ev_periodic;
    ev_vec[SRC_ALARM]    = ev_alarm;
    ev_vec[SRC_UPDATE]   = ev_update;
    en_vec[SRC_PERIODIC] = en_periodic;
    en_vec[SRC_ALARM]    = en_alarm;
    en_vec[SRC_UPDATE]   = en_update;
  end

  irq_flag_bank #(.N(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev_vec),
    .start  (start),
    .finish (finish),
    .in_read(in_read),
    .flag_q (flag_q),
    .pend_q (pend_q)
  );

  irq_read_capture #(.N(NUM_SRC), .DATA_W(DW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_end    (rd_end),
    .flags     (flag_q),
    .en        (en_vec),
    .in_read   (in_read),
    .start     (start),
    .finish    (finish),
    .irq_active(irq_active),
    .rd_data   (rd_data)
  );

  assign irq_n = ~irq_active;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_periodic,
  input logic       ev_alarm,
  input logic       ev_update,
  input logic       en_periodic,
  input logic       en_alarm,
  input logic       en_update,
  input logic       rd_start,
  input logic       rd_end,
  input logic [7:0] rd_data,
  input logic       irq_n,
  input logic       in_read,
  input logic [2:0] flag_q,
  input logic [2:0] pend_q
);
  logic [2:0] evs, ens;
  logic       st, fin;
  assign evs = {ev_update, ev_alarm, ev_periodic};
  assign ens = {en_update, en_alarm, en_periodic};
  assign st  = rd_start & ~in_read;
  assign fin = rd_end & in_read;

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evs != 3'b0 && !in_read && !rd_start) |=> ((flag_q & $past(evs)) == $past(evs)));
  // R2
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[3:0] == 4'b0);
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    st |=> (flag_q == 3'b0 && irq_n));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st |=> $stable(rd_data));
  // R5
  window_chk: assert property (@(posedge clk) disable iff (rst)
    in_read |-> (flag_q == 3'b0 && irq_n));
  // R5
  merge_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> ((flag_q & $past(pend_q)) == $past(pend_q) && pend_q == 3'b0));
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> ((flag_q & ens) != 3'b0));
  // R7
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    st |=> (rd_data[7] == !$past(irq_n)));
  // R9
  reset_chk: assert property (@(posedge clk)
    rst |=> (irq_n && flag_q == 3'b0 && pend_q == 3'b0 && !in_read && rd_data == 8'h00));
endmodule

bind irq_status_reg irq_status_chk u_chk (
  .clk(clk), .rst(rst),
  .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
  .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
  .rd_start(rd_start), .rd_end(rd_end), .rd_data(rd_data), .irq_n(irq_n),
  .in_read(in_read), .flag_q(flag_q), .pend_q(pend_q)
);

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ev  = 3'b0;
  logic [2:0] en  = 3'b0;
  logic       rd_start = 1'b0;
  logic       rd_end   = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_status_reg u_irq_status_reg (
    .clk(clk), .rst(rst),
    .ev_periodic(ev[0]), .ev_alarm(ev[1]), .ev_update(ev[2]),
    .en_periodic(en[0]), .en_alarm(en[1]), .en_update(en[2]),
    .rd_start(rd_start), .rd_end(rd_end),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // bit0 periodic -> byte bit 6, bit1 alarm -> bit 5, bit2 update -> bit 4
  function automatic logic [7:0] exp_byte(input logic [2:0] f, input logic [2:0] e);
    return {|(f & e), f[0], f[1], f[2], 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive for one cycle, return after the edge at the following negedge
  task automatic step(input logic [2:0] e, input logic s, input logic f);
    ev = e; rd_start = s; rd_end = f;
    @(negedge clk);
    ev = 3'b0; rd_start = 1'b0; rd_end = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
    chk("R9 rd_data after reset", rd_data, 8'h00);

    // sweep every event mix against every enable mix
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        en = 3'(e);
        step(3'(m), 1'b0, 1'b0);
        chk("R6 R1 irq_n after events", {7'b0, irq_n}, {7'b0, ~|(3'(m) & 3'(e))});
        step(3'b0, 1'b1, 1'b0);
        chk("R2 R7 snapshot", rd_data, exp_byte(3'(m), 3'(e)));
        chk("R3 irq_n after read", {7'b0, irq_n}, 8'h01);
        step(3'b0, 1'b0, 1'b1);
        step(3'b0, 1'b1, 1'b0);
        chk("R3 second read empty", rd_data, 8'h00);
        step(3'b0, 1'b0, 1'b1);
      end
    end

    en = 3'b111;
    // R5 event during read window
    step(3'b001, 1'b0, 1'b0);
    step(3'b0, 1'b1, 1'b0);
    chk("R2 periodic snapshot", rd_data, 8'hC0);
    step(3'b010, 1'b0, 1'b0);
    chk("R5 irq_n stays high inside window", {7'b0, irq_n}, 8'h01);
    chk("R4 rd_data stable inside window", rd_data, 8'hC0);
    step(3'b0, 1'b1, 1'b0);
    chk("R8 second start ignored", rd_data, 8'hC0);
    step(3'b100, 1'b0, 1'b1);
    chk("R5 irq_n after window closes", {7'b0, irq_n}, 8'h00);
    chk("R4 rd_data holds after window", rd_data, 8'hC0);
    step(3'b0, 1'b1, 1'b0);
    chk("R5 held events on next read", rd_data, 8'hB0);
    step(3'b0, 1'b0, 1'b1);

    // R5 event on the read-start cycle
    step(3'b100, 1'b0, 1'b0);
    step(3'b010, 1'b1, 1'b0);
    chk("R5 start-cycle event excluded", rd_data, 8'h90);
    step(3'b0, 1'b0, 1'b1);
    step(3'b0, 1'b1, 1'b0);
    chk("R5 start-cycle event kept", rd_data, 8'hA0);
    step(3'b0, 1'b0, 1'b1);

    // R8 stray read end outside a window
    en = 3'b000;
    step(3'b001, 1'b0, 1'b0);
    step(3'b0, 1'b0, 1'b1);
    chk("R8 stray end keeps irq_n", {7'b0, irq_n}, 8'h01);
    step(3'b0, 1'b1, 1'b0);
    chk("R8 R1 flag survives stray end", rd_data, 8'h40);
    step(3'b0, 1'b0, 1'b1);

    // R9 reset clears flags and pending
    en = 3'b111;
    step(3'b011, 1'b0, 1'b0);
    step(3'b0, 1'b1, 1'b0);
    step(3'b100, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 irq_n after mid reset", {7'b0, irq_n}, 8'h01);
    chk("R9 rd_data after mid reset", rd_data, 8'h00);
    step(3'b0, 1'b1, 1'b0);
    chk("R9 pending dropped by reset", rd_data, 8'h00);
    step(3'b0, 1'b0, 1'b1);
    step(3'b0, 1'b1, 1'b0);
    chk("R9 nothing merged after reset", rd_data, 8'h00);
    step(3'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule